// File: doc/BRIEF.md
# Checkpointed Register File with Rollback

This block holds the architectural registers of a core that executes speculatively between commit points. There are two register classes: integer registers, 64 entries of 32 bits, and floating-point registers, 32 entries of 80 bits. The 80-bit width holds extended-precision values. Instructions read and write only the working copy of each class. Each class has two combinational read ports and one write port.

In each class, a low-numbered subset of the registers also has a shadow copy. These are integer registers 0 to 47 and floating-point registers 0 to 15. A one-cycle commit pulse copies every shadowed working register into its shadow, which records a coherent checkpoint. A one-cycle rollback pulse copies every shadow back into its working register, which returns the class to the last checkpoint. Registers without a shadow are scratch registers and keep their values through a rollback. Both pulses act on both classes at once. The exception logic that decides when to roll back sits outside this block.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset, every working register and every shadow register in both classes reads as zero.
- R2: A write with the enable high updates the addressed working register at the clock edge. Either read port shows the new value from the next cycle on, and it holds until the next write to that register or a rollback.
- R3: When a read port's address equals the write address and the write enable is high, the port returns the write data in the same cycle, before the clock edge.
- R4: A commit pulse copies all shadowed registers in one cycle: integer indices 0 to 47 and floating-point indices 0 to 15. A later rollback returns exactly those values to the working registers.
- R5: A write in the same cycle as a commit is part of the snapshot. The write lands first and the copy sees the written value.
- R6: A rollback leaves every scratch register unchanged: integer indices 48 to 63 and floating-point indices 16 to 31.
- R7: During a rollback cycle, a write to a shadowed register is discarded, and the register takes its shadow value. A write to a scratch register in the same cycle takes effect.
- R8: When commit and rollback are high in the same cycle, the rollback is performed and no shadow register changes.
- R9: The floating-point class keeps all 80 data bits and follows R2 to R8 with its own ports and its own shadow range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_i | input | 1 | Snapshot the shadowed working registers of both classes |
| rollback_i | input | 1 | Restore the shadowed working registers of both classes |
| iwr_en | input | 1 | Integer write enable |
| iwr_addr | input | 6 | Integer write address |
| iwr_data | input | 32 | Integer write data |
| ird0_addr | input | 6 | Integer read port 0 address |
| ird0_data | output | 32 | Integer read port 0 data |
| ird1_addr | input | 6 | Integer read port 1 address |
| ird1_data | output | 32 | Integer read port 1 data |
| fwr_en | input | 1 | Floating-point write enable |
| fwr_addr | input | 5 | Floating-point write address |
| fwr_data | input | 80 | Floating-point write data |
| frd0_addr | input | 5 | Floating-point read port 0 address |
| frd0_data | output | 80 | Floating-point read port 0 data |
| frd1_addr | input | 5 | Floating-point read port 1 address |
| frd1_data | output | 80 | Floating-point read port 1 data |

## Verification
The assertions assume that no write, commit or rollback is requested while reset is low. They also assume that the addresses stay within the register counts, which the 6-bit and 5-bit address widths guarantee at the default sizes. The checkpoint property needs a specific input pattern: a commit with no write, followed directly by a rollback with no write, while the read address stays fixed. The stimulus drives every input once per cycle, away from the clock edge. The random commit and rollback pulses, and the read addresses that deliberately match the write address, make each property's precondition occur many times. The stimulus never asserts an input during reset.

// File: rtl/ckpt_pkg.sv
// Package ckpt_pkg
// Shared sizing for the checkpointed register file. The integer and
// floating-point classes each take their entry count, shadowed-entry
// count and data width from here. Shadowed entries are always the
// low-numbered ones.
package ckpt_pkg;
    localparam int INT_REGS   = 64;
    localparam int INT_SHADOW = 48;
    localparam int INT_W      = 32;
    localparam int FP_REGS    = 32;
    localparam int FP_SHADOW  = 16;
    localparam int FP_W       = 80;
endpackage

// File: rtl/ckpt_bank.sv
// Module ckpt_bank
// Storage for one register class. Entries below NSHADOW have a working
// copy and a shadow copy. The remaining entries have only a working
// copy. Rollback takes priority over commit. A write that coincides
// with a commit is included in the snapshot. A write to a shadowed
// entry during a rollback is dropped.
// Assumes: NSHADOW <= NREGS, and wr_addr < NREGS.
module ckpt_bank #(
    parameter int NREGS   = 64,
    parameter int NSHADOW = 48,
    parameter int W       = 32,
    parameter int AW      = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic               rollback_i,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [W-1:0]       wr_data,
    output logic [NREGS*W-1:0] work_flat
);
    for (genvar g = 0; g < NREGS; g++) begin : g_ent
        logic           hit;
        logic [W-1:0]   work_q;

        assign hit = wr_en && (wr_addr == AW'(g));
        assign work_flat[g*W +: W] = work_q;

        if (g < NSHADOW) begin : g_shadowed
            logic [W-1:0] shad_q;

            // Working copy: restore from the shadow on rollback, otherwise accept writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    work_q <= '0;
                end else if (rollback_i) begin
                    work_q <= shad_q;
                end else if (hit) begin
                    work_q <= wr_data;
                end
            end

            // Shadow copy: take the post-write value on a commit, unless a rollback is also requested.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shad_q <= '0;
                end else if (commit_i && !rollback_i) begin
                    shad_q <= hit ? wr_data : work_q;
                end
            end
        end else begin : g_scratch
            // Scratch entry: accepts writes in every cycle and ignores commit and rollback.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    work_q <= '0;
                end else if (hit) begin
                    work_q <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/ckpt_read_port.sv
// Module ckpt_read_port
// One combinational read port over the working set of a class. When the
// port's address matches an enabled write, the port returns the write
// data in the same cycle.
// Assumes: rd_addr < NREGS.
module ckpt_read_port #(
    parameter int NREGS = 64,
    parameter int W     = 32,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic [NREGS*W-1:0] work_flat,
    input  logic [AW-1:0]      rd_addr,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [W-1:0]       wr_data,
    output logic [W-1:0]       rd_data
);
    // Select the addressed entry, then let a matching write override it.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = work_flat[i*W +: W];
            end
        end
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_data = wr_data;
        end
    end
endmodule

// File: rtl/ckpt_class.sv
// Module ckpt_class
// One register class: a storage bank plus NRD read ports. The read
// addresses and read data are packed with port 0 in the low bits.
// Assumes: every address is below NREGS.
module ckpt_class #(
    parameter int NREGS   = 64,
    parameter int NSHADOW = 48,
    parameter int W       = 32,
    parameter int NRD     = 2,
    parameter int AW      = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              rollback_i,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*W-1:0]  rd_data
);
    logic [NREGS*W-1:0] work_flat;

    ckpt_bank #(.NREGS(NREGS), .NSHADOW(NSHADOW), .W(W), .AW(AW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_i),
        .rollback_i (rollback_i),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .work_flat  (work_flat)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        ckpt_read_port #(.NREGS(NREGS), .W(W), .AW(AW)) u_port (
            .work_flat (work_flat),
            .rd_addr   (rd_addr[p*AW +: AW]),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .rd_data   (rd_data[p*W +: W])
        );
    end
endmodule

// File: rtl/ckpt_regfile.sv
// Module ckpt_regfile
// Top level: an integer class and a floating-point class that share the
// commit and rollback pulses. Each class has two read ports and one
// write port.
// Assumes: commit, rollback and writes are held low while reset is low.
module ckpt_regfile
    import ckpt_pkg::*;
#(
    parameter int IREGS   = INT_REGS,
    parameter int ISHADOW = INT_SHADOW,
    parameter int IW      = INT_W,
    parameter int FREGS   = FP_REGS,
    parameter int FSHADOW = FP_SHADOW,
    parameter int FW      = FP_W,
    parameter int IAW     = $clog2(IREGS),
    parameter int FAW     = $clog2(FREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit_i,
    input  logic           rollback_i,
    input  logic           iwr_en,
    input  logic [IAW-1:0] iwr_addr,
    input  logic [IW-1:0]  iwr_data,
    input  logic [IAW-1:0] ird0_addr,
    output logic [IW-1:0]  ird0_data,
    input  logic [IAW-1:0] ird1_addr,
    output logic [IW-1:0]  ird1_data,
    input  logic           fwr_en,
    input  logic [FAW-1:0] fwr_addr,
    input  logic [FW-1:0]  fwr_data,
    input  logic [FAW-1:0] frd0_addr,
    output logic [FW-1:0]  frd0_data,
    input  logic [FAW-1:0] frd1_addr,
    output logic [FW-1:0]  frd1_data
);
    ckpt_class #(.NREGS(IREGS), .NSHADOW(ISHADOW), .W(IW), .NRD(2), .AW(IAW)) u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_i),
        .rollback_i (rollback_i),
        .wr_en      (iwr_en),
        .wr_addr    (iwr_addr),
        .wr_data    (iwr_data),
        .rd_addr    ({ird1_addr, ird0_addr}),
        .rd_data    ({ird1_data, ird0_data})
    );

    ckpt_class #(.NREGS(FREGS), .NSHADOW(FSHADOW), .W(FW), .NRD(2), .AW(FAW)) u_fp (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit_i),
        .rollback_i (rollback_i),
        .wr_en      (fwr_en),
        .wr_addr    (fwr_addr),
        .wr_data    (fwr_data),
        .rd_addr    ({frd1_addr, frd0_addr}),
        .rd_data    ({frd1_data, frd0_data})
    );
endmodule

// File: rtl/ckpt_regfile_chk.sv
// Module ckpt_regfile_chk
// Port-level temporal checks for ckpt_regfile, bound to every instance.
// Assumes: no write, commit or rollback while reset is low.
module ckpt_regfile_chk
    import ckpt_pkg::*;
#(
    parameter int IAW = $clog2(INT_REGS),
    parameter int FAW = $clog2(FP_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit_i,
    input logic             rollback_i,
    input logic             iwr_en,
    input logic [IAW-1:0]   iwr_addr,
    input logic [INT_W-1:0] iwr_data,
    input logic [IAW-1:0]   ird0_addr,
    input logic [INT_W-1:0] ird0_data,
    input logic [IAW-1:0]   ird1_addr,
    input logic [INT_W-1:0] ird1_data,
    input logic             fwr_en,
    input logic [FAW-1:0]   fwr_addr,
    input logic [FP_W-1:0]  fwr_data,
    input logic [FAW-1:0]   frd0_addr,
    input logic [FP_W-1:0]  frd0_data,
    input logic [FAW-1:0]   frd1_addr,
    input logic [FP_W-1:0]  frd1_data
);
    // R1: the first cycle out of reset reads zero when no write is bypassed
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !iwr_en && !fwr_en) |-> (ird1_data == '0 && frd1_data == '0));

    // R2: a written value appears on a read port in the next cycle
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(iwr_en && !rollback_i) && !iwr_en && ird0_addr == $past(iwr_addr))
        |-> (ird0_data == $past(iwr_data)));

    // R9: the same holds for the full 80-bit floating-point word
    assert_fp_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fwr_en && !rollback_i) && !fwr_en && frd0_addr == $past(fwr_addr))
        |-> (frd0_data == $past(fwr_data)));

    // R6: a scratch register is unchanged by a rollback with no write
    assert_scratch_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rollback_i && !iwr_en) && !iwr_en && $stable(ird1_addr)
         && ird1_addr >= IAW'(INT_SHADOW)) |-> $stable(ird1_data));

    // R4: a commit followed directly by a rollback restores the committed value
    assert_commit_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(commit_i && !rollback_i && !iwr_en, 2)
         && $past(rollback_i && !commit_i && !iwr_en) && !iwr_en
         && $stable(ird0_addr) && ird0_addr == $past(ird0_addr, 2)
         && ird0_addr < IAW'(INT_SHADOW)) |-> (ird0_data == $past(ird0_data, 2)));
endmodule

bind ckpt_regfile ckpt_regfile_chk u_chk (.*);

// File: tb/ckpt_regfile_test.sv
`timescale 1ns/1ps
module ckpt_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_i = 1'b0, rollback_i = 1'b0;
    logic        iwr_en = 1'b0;
    logic [5:0]  iwr_addr = '0, ird0_addr = '0, ird1_addr = '0;
    logic [31:0] iwr_data = '0;
    logic        fwr_en = 1'b0;
    logic [4:0]  fwr_addr = '0, frd0_addr = '0, frd1_addr = '0;
    logic [79:0] fwr_data = '0;
    logic [31:0] ird0_data, ird1_data;
    logic [79:0] frd0_data, frd1_data;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_iw [64];
    logic [31:0] m_is [48];
    logic [79:0] m_fw [32];
    logic [79:0] m_fs [16];

    ckpt_regfile uut (.*);

    always #5 clk = ~clk;

    task automatic chk(string tag, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_i(logic [5:0] a);
        return (iwr_en && iwr_addr == a) ? iwr_data : m_iw[a];
    endfunction

    function automatic logic [79:0] exp_f(logic [4:0] a);
        return (fwr_en && fwr_addr == a) ? fwr_data : m_fw[a];
    endfunction

    // Check all four read ports against the model, clock once, then update the model.
    task automatic tick(string tag);
        #1;
        chk((iwr_en && iwr_addr == ird0_addr) ? "R3" : tag, "int rd0", 80'(ird0_data), 80'(exp_i(ird0_addr)));
        chk((iwr_en && iwr_addr == ird1_addr) ? "R3" : tag, "int rd1", 80'(ird1_data), 80'(exp_i(ird1_addr)));
        chk((fwr_en && fwr_addr == frd0_addr) ? "R3" : "R9", "fp rd0", frd0_data, exp_f(frd0_addr));
        chk((fwr_en && fwr_addr == frd1_addr) ? "R3" : "R9", "fp rd1", frd1_data, exp_f(frd1_addr));
        @(posedge clk);
        if (rollback_i) begin
            for (int i = 0; i < 48; i++) m_iw[i] = m_is[i];
            for (int i = 0; i < 16; i++) m_fw[i] = m_fs[i];
            if (iwr_en && iwr_addr >= 6'd48) m_iw[iwr_addr] = iwr_data;
            if (fwr_en && fwr_addr >= 5'd16) m_fw[fwr_addr] = fwr_data;
        end else begin
            if (iwr_en) m_iw[iwr_addr] = iwr_data;
            if (fwr_en) m_fw[fwr_addr] = fwr_data;
            if (commit_i) begin
                for (int i = 0; i < 48; i++) m_is[i] = m_iw[i];
                for (int i = 0; i < 16; i++) m_fs[i] = m_fw[i];
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        commit_i = 0; rollback_i = 0; iwr_en = 0; fwr_en = 0;
    endtask

    task automatic dump(string tag);
        idle();
        for (int i = 0; i < 64; i += 2) begin
            ird0_addr = 6'(i); ird1_addr = 6'(i + 1);
            frd0_addr = 5'(i / 2); frd1_addr = 5'(i / 2 + 16);
            tick(tag);
        end
    endtask

    task automatic iwrite(logic [5:0] a, logic [31:0] d);
        iwr_en = 1; iwr_addr = a; iwr_data = d;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) m_iw[i] = '0;
        for (int i = 0; i < 48; i++) m_is[i] = '0;
        for (int i = 0; i < 32; i++) m_fw[i] = '0;
        for (int i = 0; i < 16; i++) m_fs[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: everything is zero out of reset
        dump("R1");

        // R2 and R9: basic writes with readback on the next cycle
        iwrite(6'd3, 32'hDEADBEEF);
        fwr_en = 1; fwr_addr = 5'd7; fwr_data = 80'h1234_5678_9ABC_DEF0_1357;
        tick("R2");
        idle(); ird0_addr = 6'd3; ird1_addr = 6'd3; frd0_addr = 5'd7;
        tick("R2");
        chk("R9", "fp 80-bit readback", frd0_data, 80'h1234_5678_9ABC_DEF0_1357);

        // R4: commit, overwrite, then rollback returns the checkpoint value
        iwrite(6'd10, 32'hAAAA_0001); tick("R4");
        idle(); commit_i = 1; tick("R4");
        idle(); iwrite(6'd10, 32'hBBBB_0002); tick("R4");
        idle(); rollback_i = 1; tick("R4");
        idle(); ird0_addr = 6'd10; #1;
        chk("R4", "int10 after rollback", 80'(ird0_data), 80'h0000_0000_0000_AAAA_0001);

        // R5: a write in the commit cycle is captured in the snapshot
        iwrite(6'd20, 32'hCCCC_0003); commit_i = 1; tick("R5");
        idle(); iwrite(6'd20, 32'hDDDD_0004); tick("R5");
        idle(); rollback_i = 1; tick("R5");
        idle(); ird0_addr = 6'd20; #1;
        chk("R5", "int20 after rollback", 80'(ird0_data), 80'h0000_0000_0000_CCCC_0003);

        // R6: a scratch register survives a rollback
        iwrite(6'd60, 32'hF00D_0005); tick("R6");
        idle(); rollback_i = 1; tick("R6");
        idle(); ird1_addr = 6'd60; #1;
        chk("R6", "int60 after rollback", 80'(ird1_data), 80'h0000_0000_0000_F00D_0005);

        // R7: a write in the rollback cycle is dropped for a shadowed register and kept for a scratch one
        idle(); rollback_i = 1; iwrite(6'd20, 32'hEEEE_0006); tick("R7");
        idle(); ird0_addr = 6'd20; #1;
        chk("R7", "int20 write during rollback", 80'(ird0_data), 80'h0000_0000_0000_CCCC_0003);
        rollback_i = 1; iwrite(6'd50, 32'h5050_0007); tick("R7");
        idle(); ird1_addr = 6'd50; #1;
        chk("R7", "int50 write during rollback", 80'(ird1_data), 80'h0000_0000_0000_5050_0007);

        // R8: commit together with rollback performs the rollback and leaves the shadows alone
        iwrite(6'd10, 32'h6666_0008); commit_i = 1; tick("R8");
        idle(); iwrite(6'd10, 32'h7777_0009); tick("R8");
        idle(); commit_i = 1; rollback_i = 1; tick("R8");
        idle(); ird0_addr = 6'd10; #1;
        chk("R8", "int10 after commit+rollback", 80'(ird0_data), 80'h0000_0000_0000_6666_0008);
        iwrite(6'd10, 32'h8888_000A); tick("R8");
        idle(); rollback_i = 1; tick("R8");
        idle(); ird0_addr = 6'd10; #1;
        chk("R8", "int10 shadow unchanged", 80'(ird0_data), 80'h0000_0000_0000_6666_0008);

        // R9: floating-point checkpoint and scratch behaviour
        fwr_en = 1; fwr_addr = 5'd15; fwr_data = {16'hABCD, 64'h0123_4567_89AB_CDEF};
        commit_i = 1; tick("R9");
        idle(); fwr_en = 1; fwr_addr = 5'd15; fwr_data = '1; tick("R9");
        fwr_addr = 5'd16; fwr_data = {16'h1111, 64'h2222_3333_4444_5555}; tick("R9");
        idle(); rollback_i = 1; tick("R9");
        idle(); frd0_addr = 5'd15; frd1_addr = 5'd16; #1;
        chk("R9", "fp15 after rollback", frd0_data, {16'hABCD, 64'h0123_4567_89AB_CDEF});
        chk("R9", "fp16 scratch kept", frd1_data, {16'h1111, 64'h2222_3333_4444_5555});

        // Random traffic, checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            commit_i = ($urandom % 12) == 0;
            rollback_i = ($urandom % 14) == 0;
            iwr_en = ($urandom % 4) != 0;
            iwr_addr = 6'($urandom); iwr_data = $urandom;
            fwr_en = ($urandom % 4) != 0;
            fwr_addr = 5'($urandom); fwr_data = {16'($urandom), $urandom, $urandom};
            ird0_addr = (($urandom % 4) == 0) ? iwr_addr : 6'($urandom);
            ird1_addr = 6'($urandom);
            frd0_addr = (($urandom % 4) == 0) ? fwr_addr : 5'($urandom);
            frd1_addr = 5'($urandom);
            tick(rollback_i ? "R7" : (commit_i ? "R5" : "R2"));
        end

        // R4: full sweep after a final rollback
        idle(); rollback_i = 1; tick("R4");
        dump("R4");
        summary();
    end
endmodule